// File: doc/BRIEF.md
# Filtered Command/Status Word Queue

This block keeps a first-in first-out record of 16-bit protocol words for a host processor to collect later. When the surrounding logic works as a terminal, the words offered are received command words. When it works as a bus controller, they are the status responses that came back. Each offered word comes with a mode flag and a flag that says whether the message carried data words. In terminal mode the block drops commands that carry no data, so mode commands without data never occupy the queue.

The host removes entries by reading register address zero. Each such read returns the oldest entry one cycle later and frees its slot. Discrete full and empty outputs report the queue state. If a word that should be kept arrives while the queue is full, it is lost and a sticky overflow flag is raised. The host clears that flag by writing register address one.

Top module: `cmdq_top`

## Requirements
- R1: After a synchronous reset, `empty` is 1, `full` is 0, `overflow` is 0 and `host_rdata` is 0.
- R2: With `wr_mode` = 0 (terminal), an offered word is stored only when `wr_has_data` = 1. A word offered with `wr_has_data` = 0 is discarded and never reaches the queue.
- R3: With `wr_mode` = 1 (controller), every offered word is stored, whatever the value of `wr_has_data`.
- R4: A cycle with `host_rd` = 1 and `host_addr` = 0 puts the oldest stored word on `host_rdata` after the next clock edge and removes it. Words leave in the order they were stored.
- R5: A read at any address other than 0 loads 0 into `host_rdata` and leaves the queue contents unchanged.
- R6: `full` is 1 exactly when DEPTH (32) words are stored. `empty` is 1 exactly when no word is stored.
- R7: A word that should be stored but arrives while the queue is full, with no pop in the same cycle, is dropped. The stored contents stay unchanged and `overflow` becomes 1 on the next edge and stays 1.
- R8: A cycle with `host_wr` = 1 and `host_addr` = 1 clears `overflow`. If a drop happens in the same cycle, the set wins.
- R9: A pop read while the queue is empty loads 0 into `host_rdata` and moves no pointer. A word pushed in that same cycle is kept.
- R10: A push and a pop in the same cycle leave the occupancy unchanged. This holds when the queue is full as well, so no overflow is raised in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A word is offered this cycle |
| wr_word | input | WIDTH | Offered command or status word |
| wr_mode | input | 1 | 0 = terminal (command words), 1 = controller (status words) |
| wr_has_data | input | 1 | The message carries data words |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_rdata | output | WIDTH | Registered read data |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no word |
| overflow | output | 1 | Sticky flag: a word was lost to a full queue |

## Verification
The bench builds the block with its default values: DEPTH 32, WIDTH 16 and ADDR_W 4. With a depth of 32, a short run can fill the queue to the brim. It can then drive it past full, wrap both pointers and pop it back down to empty. That brings the overflow, the push-and-pop-while-full case and the pop-while-empty case within reach in a few hundred cycles. A 4-bit address leaves room to check reads at non-zero addresses and the clear write at address one.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    typedef enum logic {
        MODE_TERMINAL   = 1'b0,
        MODE_CONTROLLER = 1'b1
    } src_mode_e;

    typedef struct packed {
        src_mode_e mode;
        logic      has_data;
    } wr_tag_t;

    localparam int unsigned POP_ADDR = 0;
    localparam int unsigned CLR_ADDR = 1;

    // Decide whether an offered word belongs in the host queue.
    function automatic logic admit_word(input wr_tag_t tag);
        return (tag.mode == MODE_CONTROLLER) || tag.has_data;
    endfunction

endpackage

// File: rtl/cmdq_filter.sv
module cmdq_filter
    import cmdq_pkg::*;
(
    input  logic    wr_valid,
    input  wr_tag_t tag,
    output logic    push
);
    always_comb push = wr_valid && admit_word(tag);
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             drop
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop_ok, push_ok;

    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        drop    = push && full && !pop_ok;
        dout    = mem[rd_ptr];
    end

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= next_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R10
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty) |=> $stable(count));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> empty);

endmodule

// File: rtl/cmdq_host.sv
module cmdq_host
    import cmdq_pkg::*;
#(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WIDTH-1:0]  fifo_dout,
    input  logic              empty,
    input  logic              drop,
    output logic              pop,
    output logic [WIDTH-1:0]  rdata,
    output logic              overflow
);
    logic at_pop, at_clr;

    always_comb begin
        at_pop = (host_addr == ADDR_W'(POP_ADDR));
        at_clr = (host_addr == ADDR_W'(CLR_ADDR));
        pop    = host_rd && at_pop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            overflow <= 1'b0;
        end else begin
            if (host_rd) rdata <= (at_pop && !empty) ? fifo_dout : '0;
            if (drop)                   overflow <= 1'b1;
            else if (host_wr && at_clr) overflow <= 1'b0;
        end
    end

    // R7
    overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> overflow);

    // R8
    overflow_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && at_clr && !drop) |=> !overflow);

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && empty) |=> (rdata == '0));

endmodule

// File: rtl/cmdq_top.sv
module cmdq_top
    import cmdq_pkg::*;
#(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [WIDTH-1:0]  wr_word,
    input  logic              wr_mode,
    input  logic              wr_has_data,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [WIDTH-1:0]  host_rdata,
    output logic              full,
    output logic              empty,
    output logic              overflow
);
    wr_tag_t          tag;
    logic             push, pop, drop;
    logic [WIDTH-1:0] fifo_dout;
    logic [CNT_W-1:0] count;

    always_comb begin
        tag.mode     = src_mode_e'(wr_mode);
        tag.has_data = wr_has_data;
    end

    cmdq_filter u_filter (
        .wr_valid (wr_valid),
        .tag      (tag),
        .push     (push)
    );

    cmdq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (wr_word),
        .dout  (fifo_dout),
        .count (count),
        .full  (full),
        .empty (empty),
        .drop  (drop)
    );

    cmdq_host #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_host (
        .clk       (clk),
        .rst       (rst),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .fifo_dout (fifo_dout),
        .empty     (empty),
        .drop      (drop),
        .pop       (pop),
        .rdata     (host_rdata),
        .overflow  (overflow)
    );

    // R2
    terminal_filter_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_mode && !wr_has_data && !host_rd) |=> $stable(count));

    // R3
    controller_admit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_mode && !full && !host_rd) |=> (count == $past(count) + 1'b1));

endmodule

// File: tb/tb_cmdq_top.sv
module tb_cmdq_top;
    localparam int DEPTH  = 32;
    localparam int WIDTH  = 16;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid, wr_mode, wr_has_data;
    logic [WIDTH-1:0]  wr_word;
    logic              host_rd, host_wr;
    logic [ADDR_W-1:0] host_addr;
    logic [WIDTH-1:0]  host_rdata;
    logic              full, empty, overflow;

    int errors = 0;
    int checks = 0;
    logic [WIDTH-1:0] sb[$];
    logic model_ovf = 1'b0;

    always #5 clk = ~clk;

    cmdq_top #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
        .wr_mode(wr_mode), .wr_has_data(wr_has_data), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_rdata(host_rdata),
        .full(full), .empty(empty), .overflow(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_valid = 0; wr_word = '0; wr_mode = 0; wr_has_data = 0;
        host_rd = 0; host_wr = 0; host_addr = '0;
    endtask

    // Driver: one cycle of activity, scoreboard updated from the requirements.
    task automatic cycle(input logic wv, input logic [WIDTH-1:0] w, input logic m,
                         input logic hd, input logic rd, input logic [ADDR_W-1:0] a,
                         input string req);
        logic keep, popd, was_empty;
        logic [WIDTH-1:0] exp_rd;
        wr_valid = wv; wr_word = w; wr_mode = m; wr_has_data = hd;
        host_rd = rd; host_addr = a;
        keep = wv && (m || hd);
        popd = rd && (a == 0) && (sb.size() > 0);
        was_empty = (sb.size() == 0);
        exp_rd = popd ? sb[0] : '0;
        @(posedge clk);
        if (popd) void'(sb.pop_front());
        if (keep) begin
            if (sb.size() < DEPTH) sb.push_back(w);
            else model_ovf = 1'b1;
        end
        @(negedge clk);
        idle();
        if (rd) monitor(req, exp_rd, was_empty);
    endtask

    // Monitor: compare read data and the discretes against the model.
    task automatic monitor(input string req, input logic [WIDTH-1:0] exp_rd, input logic was_empty);
        check(req, host_rdata, exp_rd);
        if (was_empty) check({req, " R9"}, host_rdata, '0);
    endtask

    task automatic flags(input string req);
        check({req, " R6 empty"}, empty, sb.size() == 0);
        check({req, " R6 full"},  full,  sb.size() == DEPTH);
        check({req, " R7 overflow"}, overflow, model_ovf);
    endtask

    task automatic drain(input string req);
        while (sb.size() > 0) cycle(0, '0, 0, 0, 1, 0, req);
        flags(req);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        check("R1 empty", empty, 1); check("R1 full", full, 0);
        check("R1 overflow", overflow, 0); check("R1 rdata", host_rdata, 0);

        // R2 terminal mode: data-less command discarded, data command kept
        cycle(1, 16'h1111, 0, 0, 0, 0, "R2");
        flags("R2 after no-data");
        cycle(1, 16'h2222, 0, 1, 0, 0, "R2");
        cycle(1, 16'h3333, 0, 0, 0, 0, "R2");
        // R3 controller mode keeps everything
        cycle(1, 16'h4444, 1, 0, 0, 0, "R3");
        cycle(1, 16'h5555, 1, 1, 0, 0, "R3");
        // R5 read at other address returns zero and keeps queue
        cycle(0, '0, 0, 0, 1, 4'h3, "R5");
        check("R5 count kept", sb.size(), 3);
        // R4 FIFO order
        drain("R4");
        // R9 pop while empty, with a push in the same cycle
        cycle(0, '0, 0, 0, 1, 0, "R9 empty read");
        cycle(1, 16'hABCD, 1, 0, 1, 0, "R9 push kept");
        flags("R9");
        drain("R9 drain");

        // R6 fill to full, R7 overflow
        for (int i = 0; i < DEPTH; i++) cycle(1, WIDTH'(16'hA000 + i), 1, 0, 0, 0, "R6");
        flags("R6 full");
        cycle(1, 16'hDEAD, 0, 1, 0, 0, "R7");
        flags("R7 drop");
        cycle(1, 16'hBEEF, 0, 0, 0, 0, "R2 at full");
        flags("R2 at full no overflow change");
        // R10 push and pop while full
        cycle(1, 16'hC0DE, 1, 1, 1, 0, "R10 pop");
        flags("R10 occupancy");
        // R8 clear overflow
        host_wr = 1; host_addr = 4'h1;
        @(posedge clk); model_ovf = 0; @(negedge clk); idle();
        check("R8 cleared", overflow, 0);
        // R8 set wins over clear
        wr_valid = 1; wr_mode = 1; wr_word = 16'hFFFF; host_wr = 1; host_addr = 4'h1;
        @(posedge clk); model_ovf = 1; @(negedge clk); idle();
        check("R8 set wins", overflow, 1);
        // R10 push and pop while partially filled
        cycle(0, '0, 0, 0, 1, 0, "R4 pop");
        cycle(1, 16'h7777, 0, 1, 1, 0, "R10 mid");
        flags("R10 mid");
        drain("R4 final drain");
        check("R7 sticky", overflow, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule